// File: doc/BRIEF.md
# Sliding-Window Register File

This block is the register file of a processor core that gives each procedure its own small set of registers. A large physical array of 128 words sits behind a window of 8 architectural registers. A window base selects which group of eight physical words the running procedure sees. A call strobe moves the base forward by one group, so the callee starts on a fresh set. A return strobe moves the base back to the caller's group, and the caller's values are still there.

Two combinational read ports and one write port all take 3-bit architectural indices. A write reaches a read port in the same cycle when both name the same architectural register. The window never leaves the physical array. A call from the last group or a return from the first group is refused, and a one-cycle flag reports it. Moving values to memory when this happens belongs to the surrounding core.

Top module: `winreg_file`

## Requirements
- R1: After reset the window base is group 0 and both `ovf_o` and `unf_o` are low.
- R2: Architectural index `a` (3 bits) under window base `b` (0..15) addresses physical word `b*8 + a`. Words in other groups are not affected by a write.
- R3: A call (`call_i`=1, `ret_i`=0) with base below 15 raises the base by one at the clock edge.
- R4: A return (`ret_i`=1, `call_i`=0) with base above 0 lowers the base by one at the clock edge. The caller's words then read back unchanged.
- R5: A call with base 15 leaves the base unchanged. `ovf_o` is high in the single cycle after that edge.
- R6: A return with base 0 leaves the base unchanged. `unf_o` is high in the single cycle after that edge.
- R7: With `call_i` and `ret_i` both high, the base is unchanged and neither flag rises.
- R8: Read data is combinational. When `we_i` is high and a read index equals `waddr_i`, that port returns `wdata_i` in the same cycle.
- R9: A write in the same cycle as a call or return lands in the group selected by the base before the move.
- R10: The two read ports work independently and may name any two registers, including the same one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Move the window one group forward |
| ret_i | input | 1 | Move the window one group back |
| we_i | input | 1 | Write enable |
| waddr_i | input | 3 | Architectural write index |
| wdata_i | input | 32 | Write data |
| raddr_a_i | input | 3 | Architectural index, read port A |
| rdata_a_o | output | 32 | Read data, port A |
| raddr_b_i | input | 3 | Architectural index, read port B |
| rdata_b_o | output | 32 | Read data, port B |
| ovf_o | output | 1 | Refused call, one cycle |
| unf_o | output | 1 | Refused return, one cycle |

## Verification
The assertions check the window base on every cycle. They cover the increment on a call, the decrement on a return, the hold together with the matching flag at either end of the array, and the hold when both strobes are high. They also check same-cycle forwarding on both read ports. Only the bench scenarios can show that stored data survives a call and return round trip and that each group is kept apart from the others. The same holds for a write that coincides with a move landing in the old group. The bench shows these by filling every group and reading each one back on the way down.

// File: rtl/winreg_pkg.sv
package winreg_pkg;

  // Outcome of the call/return strobes for one cycle
  typedef enum logic [2:0] {
    WEV_NONE = 3'd0,
    WEV_ADV  = 3'd1,
    WEV_BACK = 3'd2,
    WEV_OVF  = 3'd3,
    WEV_UNF  = 3'd4
  } win_evt_e;

  function automatic win_evt_e classify_move(input logic call, input logic ret,
                                             input logic at_top, input logic at_bottom);
    win_evt_e e;
    e = WEV_NONE;
    if (call && !ret) e = at_top ? WEV_OVF : WEV_ADV;
    else if (ret && !call) e = at_bottom ? WEV_UNF : WEV_BACK;
    return e;
  endfunction

endpackage

// File: rtl/winreg_window.sv
module winreg_window
  import winreg_pkg::*;
#(
  parameter int NUM_WIN = 16,
  localparam int BASE_W = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_i,
  input  logic              ret_i,
  output logic [BASE_W-1:0] base_o,
  output logic              ovf_o,
  output logic              unf_o
);

  localparam logic [BASE_W-1:0] TOP_BASE = BASE_W'(NUM_WIN - 1);

  logic [BASE_W-1:0] base_q;
  win_evt_e          evt;

  always_comb evt = classify_move(call_i, ret_i, base_q == TOP_BASE, base_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      ovf_o  <= 1'b0;
      unf_o  <= 1'b0;
    end else begin
      case (evt)
        WEV_ADV:  base_q <= base_q + 1'b1;
        WEV_BACK: base_q <= base_q - 1'b1;
        default:  base_q <= base_q;
      endcase
      ovf_o <= (evt == WEV_OVF);
      unf_o <= (evt == WEV_UNF);
    end
  end

  assign base_o = base_q;

endmodule

// File: rtl/winreg_storage.sv
module winreg_storage #(
  parameter int PHYS_REGS = 128,
  parameter int DATA_W    = 32,
  parameter int NRD       = 2,
  localparam int PHYS_W   = $clog2(PHYS_REGS)
) (
  input  logic                          clk,
  input  logic                          we_i,
  input  logic [PHYS_W-1:0]             waddr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [NRD-1:0][PHYS_W-1:0]    raddr_i,
  output logic [NRD-1:0][DATA_W-1:0]    rdata_o
);

  logic [DATA_W-1:0] mem [PHYS_REGS];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = mem[raddr_i[p]];
  end

endmodule

// File: rtl/winreg_rd_fwd.sv
module winreg_rd_fwd #(
  parameter int DATA_W = 32,
  parameter int ARCH_W = 3
) (
  input  logic [ARCH_W-1:0] raddr_i,
  input  logic              we_i,
  input  logic [ARCH_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] arr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic hit;
  assign hit     = we_i && (raddr_i == waddr_i);
  assign rdata_o = hit ? wdata_i : arr_i;

endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
  parameter int PHYS_REGS = 128,
  parameter int WIN_REGS  = 8,
  parameter int DATA_W    = 32,
  localparam int NUM_WIN  = PHYS_REGS / WIN_REGS,
  localparam int BASE_W   = $clog2(NUM_WIN),
  localparam int ARCH_W   = $clog2(WIN_REGS),
  localparam int PHYS_W   = $clog2(PHYS_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              we_i,
  input  logic [ARCH_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ARCH_W-1:0] raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [ARCH_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o,
  output logic              ovf_o,
  output logic              unf_o
);

  localparam int NRD = 2;

  function automatic logic [PHYS_W-1:0] phys_idx(input logic [BASE_W-1:0] b,
                                                 input logic [ARCH_W-1:0] a);
    return PHYS_W'(b) * PHYS_W'(WIN_REGS) + PHYS_W'(a);
  endfunction

  logic [BASE_W-1:0]             win_base;
  logic [NRD-1:0][ARCH_W-1:0]    rd_arch;
  logic [NRD-1:0][PHYS_W-1:0]    rd_phys;
  logic [NRD-1:0][DATA_W-1:0]    rd_arr;
  logic [NRD-1:0][DATA_W-1:0]    rd_out;
  logic [PHYS_W-1:0]             wr_phys;

  winreg_window #(.NUM_WIN(NUM_WIN)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .call_i (call_i),
    .ret_i  (ret_i),
    .base_o (win_base),
    .ovf_o  (ovf_o),
    .unf_o  (unf_o)
  );

  // the write sees the base before any move on this edge
  assign wr_phys    = phys_idx(win_base, waddr_i);
  assign rd_arch[0] = raddr_a_i;
  assign rd_arch[1] = raddr_b_i;

  for (genvar p = 0; p < NRD; p++) begin : g_port
    assign rd_phys[p] = phys_idx(win_base, rd_arch[p]);
    winreg_rd_fwd #(.DATA_W(DATA_W), .ARCH_W(ARCH_W)) u_fwd (
      .raddr_i (rd_arch[p]),
      .we_i    (we_i),
      .waddr_i (waddr_i),
      .wdata_i (wdata_i),
      .arr_i   (rd_arr[p]),
      .rdata_o (rd_out[p])
    );
  end

  winreg_storage #(.PHYS_REGS(PHYS_REGS), .DATA_W(DATA_W), .NRD(NRD)) u_store (
    .clk     (clk),
    .we_i    (we_i),
    .waddr_i (wr_phys),
    .wdata_i (wdata_i),
    .raddr_i (rd_phys),
    .rdata_o (rd_arr)
  );

  assign rdata_a_o = rd_out[0];
  assign rdata_b_o = rd_out[1];

endmodule

// File: rtl/winreg_file_chk.sv
module winreg_file_chk #(
  parameter int BASE_W   = 4,
  parameter int ARCH_W   = 3,
  parameter int DATA_W   = 32,
  parameter int TOP_BASE = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              call_i,
  input logic              ret_i,
  input logic              we_i,
  input logic [ARCH_W-1:0] waddr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [ARCH_W-1:0] raddr_a_i,
  input logic [DATA_W-1:0] rdata_a_o,
  input logic [ARCH_W-1:0] raddr_b_i,
  input logic [DATA_W-1:0] rdata_b_o,
  input logic [BASE_W-1:0] base,
  input logic              ovf_o,
  input logic              unf_o
);

  localparam logic [BASE_W-1:0] TOPB = BASE_W'(TOP_BASE);

  // R3
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !ret_i && base != TOPB) |=> (base == $past(base) + 1'b1) && !ovf_o);

  // R4
  retreat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i && base != '0) |=> (base == $past(base) - 1'b1) && !unf_o);

  // R5
  overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !ret_i && base == TOPB) |=> ovf_o && $stable(base));

  // R6
  underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i && base == '0) |=> unf_o && $stable(base));

  // R7
  both_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && ret_i) |=> $stable(base) && !ovf_o && !unf_o);

  // R5
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> $past(call_i) && !$past(ret_i));

  // R6
  unf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |-> $past(ret_i) && !$past(call_i));

  // R8
  fwd_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && raddr_a_i == waddr_i) |-> rdata_a_o == wdata_i);

  // R10
  fwd_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && raddr_b_i == waddr_i) |-> rdata_b_o == wdata_i);

endmodule

bind winreg_file winreg_file_chk #(
  .BASE_W   (BASE_W),
  .ARCH_W   (ARCH_W),
  .DATA_W   (DATA_W),
  .TOP_BASE (NUM_WIN - 1)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .call_i    (call_i),
  .ret_i     (ret_i),
  .we_i      (we_i),
  .waddr_i   (waddr_i),
  .wdata_i   (wdata_i),
  .raddr_a_i (raddr_a_i),
  .rdata_a_o (rdata_a_o),
  .raddr_b_i (raddr_b_i),
  .rdata_b_o (rdata_b_o),
  .base      (win_base),
  .ovf_o     (ovf_o),
  .unf_o     (unf_o)
);

// File: tb/winreg_file_tb.sv
`timescale 1ns/1ps
module winreg_file_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call_i = 1'b0, ret_i = 1'b0, we_i = 1'b0;
  logic [2:0]  waddr_i = '0, raddr_a_i = '0, raddr_b_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_a_o, rdata_b_o;
  logic        ovf_o, unf_o;

  int checks = 0;
  int errors = 0;
  int cyc_cnt = 0;

  int          m_base = 0;
  logic [31:0] m_mem [128];
  logic        m_ovf = 1'b0, m_unf = 1'b0;

  always #5 clk = ~clk;

  winreg_file u_dut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .we_i(we_i), .waddr_i(waddr_i), .wdata_i(wdata_i),
    .raddr_a_i(raddr_a_i), .rdata_a_o(rdata_a_o),
    .raddr_b_i(raddr_b_i), .rdata_b_o(rdata_b_o),
    .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt == 50000) begin
      errors++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected < 50000", cyc_cnt);
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int w, input int r, input int salt);
    return 32'h5A00_0000 ^ (salt << 16) ^ (w << 8) ^ (r * 32'h11);
  endfunction

  // one clock with the given strobes; model updates with the pre-move base
  task automatic cyc(input logic c, input logic r, input logic we,
                     input int wa, input logic [31:0] wd, input string req);
    call_i = c; ret_i = r; we_i = we; waddr_i = 3'(wa); wdata_i = wd;
    @(posedge clk); #1;
    if (we) m_mem[m_base*8 + wa] = wd;
    m_ovf = 1'b0; m_unf = 1'b0;
    if (c && !r) begin
      if (m_base == 15) m_ovf = 1'b1; else m_base++;
    end else if (r && !c) begin
      if (m_base == 0) m_unf = 1'b1; else m_base--;
    end
    call_i = 1'b0; ret_i = 1'b0; we_i = 1'b0;
    check({req, " ovf"}, {31'd0, ovf_o}, {31'd0, m_ovf});
    check({req, " unf"}, {31'd0, unf_o}, {31'd0, m_unf});
  endtask

  // read the whole current window, port B in reverse order
  task automatic read_win(input string req);
    for (int k = 0; k < 8; k++) begin
      raddr_a_i = 3'(k); raddr_b_i = 3'(7 - k); #1;
      check({req, " portA"}, rdata_a_o, m_mem[m_base*8 + k]);
      check({req, " portB"}, rdata_b_o, m_mem[m_base*8 + 7 - k]);
    end
  endtask

  initial begin
    for (int i = 0; i < 128; i++) m_mem[i] = 'x;
    repeat (3) @(posedge clk);
    #1;
    // R1: flags low in reset
    check("R1 ovf reset", {31'd0, ovf_o}, 32'd0);
    check("R1 unf reset", {31'd0, unf_o}, 32'd0);
    rst_n = 1'b1;
    // R1/R6: return straight after reset is refused from group 0
    cyc(0, 1, 0, 0, '0, "R6 return at reset");

    // R2/R3/R5: fill every group, then call (last call overflows)
    for (int w = 0; w < 16; w++) begin
      for (int k = 0; k < 8; k++) cyc(0, 0, 1, k, pat(w, k, 1), "R2 fill");
      read_win("R2 window contents");
      cyc(1, 0, 0, 0, '0, "R3 R5 call");
    end
    read_win("R5 group 15 after refused call");
    cyc(1, 0, 0, 0, '0, "R5 second refused call");

    // R4/R6: walk back down checking every group survived
    for (int w = 15; w >= 0; w--) begin
      read_win("R4 caller data intact");
      cyc(0, 1, 0, 0, '0, "R4 R6 return");
    end
    read_win("R6 group 0 after refused return");

    // R7: both strobes at the bottom and in the middle
    cyc(1, 1, 0, 0, '0, "R7 both at group 0");
    read_win("R7 group 0 kept");
    cyc(1, 0, 0, 0, '0, "R3 call to group 1");
    cyc(1, 1, 0, 0, '0, "R7 both at group 1");
    read_win("R7 group 1 kept");

    // R9: write coinciding with a call lands in the old group
    cyc(1, 0, 1, 2, 32'hCAFE_0001, "R9 write with call");
    read_win("R9 new group untouched");
    cyc(0, 1, 0, 0, '0, "R9 return");
    raddr_a_i = 3'd2; #1;
    check("R9 old group holds write", rdata_a_o, 32'hCAFE_0001);
    // R9: write coinciding with a return
    cyc(0, 1, 1, 5, 32'hBEEF_0002, "R9 write with return");
    read_win("R9 caller group after return");
    cyc(1, 0, 0, 0, '0, "R9 call back");
    raddr_b_i = 3'd5; #1;
    check("R9 write went to callee group", rdata_b_o, 32'hBEEF_0002);

    // R8/R10: same-cycle forwarding on both ports, and a non-matching port
    for (int k = 0; k < 8; k++) begin
      we_i = 1'b1; waddr_i = 3'(k); wdata_i = pat(1, k, 7);
      raddr_a_i = 3'(k); raddr_b_i = 3'((k + 1) % 8); #1;
      check("R8 forward port A", rdata_a_o, pat(1, k, 7));
      check("R10 port B unaffected", rdata_b_o, m_mem[m_base*8 + (k + 1) % 8]);
      raddr_b_i = 3'(k); #1;
      check("R10 forward port B", rdata_b_o, pat(1, k, 7));
      @(posedge clk); #1;
      m_mem[m_base*8 + k] = pat(1, k, 7);
      we_i = 1'b0;
    end
    read_win("R8 forwarded data stored");

    // R1: reset returns to group 0
    rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    m_base = 0;
    read_win("R1 group 0 after reset");
    cyc(0, 1, 0, 0, '0, "R1 R6 return after reset");

    summary();
    $finish;
  end

endmodule